// File: doc/BRIEF.md
# Bit-Configurable Flag Port with Interrupt Steering

This block is a general-purpose parallel I/O port of `WIDTH` bits (16 by default). Software sets each bit as an input or an output. An output bit drives the value held in a data register. An input bit goes through a two-stage synchroniser and then sets a status flag. Per bit, software chooses whether the flag follows an active level or latches an active transition. A polarity register decides, per bit, whether "active" means high or rising, or low or falling.

Two interrupt lines read the flag vector, and each line has its own mask register, so any flag can be steered to either line or to both. A separate wake-up output is formed purely from gates on the raw pins, so it can rouse a sleeping system while the clock is stopped. Software reaches the registers through a single-cycle write port and a combinational read port that share one address bus.

Top module: `gpio_flag_port`

## Requirements
- R1: After reset every register is zero, so no pin is driven, the flag vector reads zero, and irq_a, irq_b and wake_o are all low.
- R2: A bit set to 1 in the direction register (address 1) drives its pin. pin_oe equals the direction register, and pin_out equals the output data register (address 0), from the clock edge that writes them.
- R3: When an input bit is in level mode (its bit in the sensitivity register, address 2, is 0), its flag equals the synchronised active level. The flag changes on the third rising clock edge after the pin changes. Writing 1 to that bit of the flag register (address 4) does not clear it while the level stays active.
- R4: When a bit in the polarity register (address 3) is 1, that bit is active low in level mode and falling-edge in edge mode. When it is 0, the bit is active high or rising-edge.
- R5: When an input bit is in edge mode (sensitivity bit 1), its flag sets on a synchronised transition into the active state. It stays set after the pin returns, and it clears only when software writes 1 to that bit of the flag register.
- R6: The flag of any bit configured as an output reads 0, whatever its pin does.
- R7: irq_a is the OR of the flags ANDed with mask register A (address 5). irq_b is the same with mask register B (address 6).
- R8: wake_o is the OR, over bits that are inputs and enabled in the wake-enable register (address 7), of the raw pin XOR its polarity bit. It contains no register and responds with no clock edge.
- R9: Reading address 0 returns the data register value for output bits and the synchronised pin value for input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data for addr |
| pin_in | input | WIDTH | Pin input values from the pads |
| pin_out | output | WIDTH | Output data per pin |
| pin_oe | output | WIDTH | Output enable per pin |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |
| wake_o | output | 1 | Unregistered wake-up request |

## Verification
The bench builds the port with its default parameters: sixteen bits and a two-flop synchroniser. Sixteen bits leave room to keep disjoint bits in output, level, inverted-level, rising-edge and falling-edge roles simultaneously. Each bit's flag can then be watched without disturbing the others. The two-stage synchroniser fixes the pin-to-flag latency at three edges, so every expected flag and interrupt value is sampled in a known cycle.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_SENSE  = 3'd2,
    REG_POL    = 3'd3,
    REG_FLAG   = 3'd4,
    REG_MASK_A = 3'd5,
    REG_MASK_B = 3'd6,
    REG_WAKE   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] sense,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] active;
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;

  function automatic logic [WIDTH-1:0] f_active(input logic [WIDTH-1:0] lvl,
                                                input logic [WIDTH-1:0] inv);
    return lvl ^ inv;
  endfunction

  assign active   = f_active(sync_in, pol);
  assign edge_hit = active & ~prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (dir[i])        flag_d[i] = 1'b0;
      else if (sense[i]) flag_d[i] = (flag_q[i] & ~clr[i]) | edge_hit[i];
      else               flag_d[i] = active[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= active;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_q ^ $past(active)) & $past(~sense & ~dir)) == '0)); // R3
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q & sense & ~clr & ~dir) & ~flag_q & sense & ~dir) == '0)); // R5
  AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(dir)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int WIDTH = 16,
  parameter int LINES = 2
) (
  input  logic [WIDTH-1:0]             flags,
  input  logic [LINES-1:0][WIDTH-1:0]  masks,
  output logic [LINES-1:0]             irq
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign irq[l] = |(flags & masks[l]);
  end
endmodule

// File: rtl/gpio_flag_port.sv
module gpio_flag_port
  import gpio_flag_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_o
);
  localparam int IRQ_LINES = 2;

  logic [WIDTH-1:0] data_q, dir_q, sense_q, pol_q, mask_a_q, mask_b_q, wake_en_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] flags;
  logic [WIDTH-1:0] clr_req;
  logic [IRQ_LINES-1:0] irq_vec;

  function automatic logic [WIDTH-1:0] f_readback(input logic [WIDTH-1:0] d,
                                                  input logic [WIDTH-1:0] drv,
                                                  input logic [WIDTH-1:0] smp);
    return (d & drv) | (~d & smp);
  endfunction

  function automatic logic f_wake(input logic [WIDTH-1:0] en,
                                  input logic [WIDTH-1:0] d,
                                  input logic [WIDTH-1:0] raw,
                                  input logic [WIDTH-1:0] inv);
    return |(en & ~d & (raw ^ inv));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      dir_q     <= '0;
      sense_q   <= '0;
      pol_q     <= '0;
      mask_a_q  <= '0;
      mask_b_q  <= '0;
      wake_en_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DATA:   data_q    <= wr_data;
        REG_DIR:    dir_q     <= wr_data;
        REG_SENSE:  sense_q   <= wr_data;
        REG_POL:    pol_q     <= wr_data;
        REG_MASK_A: mask_a_q  <= wr_data;
        REG_MASK_B: mask_b_q  <= wr_data;
        REG_WAKE:   wake_en_q <= wr_data;
        default:    ;
      endcase
    end
  end

  assign clr_req = (wr_en && addr == REG_FLAG) ? wr_data : '0;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_flag_bank #(.WIDTH(WIDTH)) bank_i (
    .clk(clk), .rst_n(rst_n), .sync_in(pin_sync), .dir(dir_q),
    .sense(sense_q), .pol(pol_q), .clr(clr_req), .flags(flags)
  );

  gpio_irq_route #(.WIDTH(WIDTH), .LINES(IRQ_LINES)) route_i (
    .flags(flags), .masks({mask_b_q, mask_a_q}), .irq(irq_vec)
  );

  assign irq_a   = irq_vec[0];
  assign irq_b   = irq_vec[1];
  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign wake_o  = f_wake(wake_en_q, dir_q, pin_in, pol_q);

  always_comb begin
    case (addr)
      REG_DATA:   rd_data = f_readback(dir_q, data_q, pin_sync);
      REG_DIR:    rd_data = dir_q;
      REG_SENSE:  rd_data = sense_q;
      REG_POL:    rd_data = pol_q;
      REG_FLAG:   rd_data = flags;
      REG_MASK_A: rd_data = mask_a_q;
      REG_MASK_B: rd_data = mask_b_q;
      default:    rd_data = wake_en_q;
    endcase
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIR) |=> (pin_oe == $past(wr_data))); // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |-> (flags != '0)); // R7
  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ((wake_en_q & ~dir_q) != '0)); // R8
endmodule

// File: tb/gpio_flag_port_tb_top.sv
module gpio_flag_port_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq_a, irq_b, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef enum int {OBS_RD, OBS_IRQA, OBS_IRQB, OBS_WAKE, OBS_OE, OBS_OUT} obs_e;
  typedef struct {
    string        req;
    obs_e         kind;
    logic [W-1:0] exp;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  always #2.5 clk = ~clk;

  gpio_flag_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_a(irq_a), .irq_b(irq_b), .wake_o(wake_o)
  );

  always @(chk_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        OBS_RD:   act = rd_data;
        OBS_IRQA: act = {{(W-1){1'b0}}, irq_a};
        OBS_IRQB: act = {{(W-1){1'b0}}, irq_b};
        OBS_WAKE: act = {{(W-1){1'b0}}, wake_o};
        OBS_OE:   act = pin_oe;
        default:  act = pin_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_obs(input string req, input obs_e kind, input logic [W-1:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    -> chk_ev;
    #0.1;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    addr = a;
    #0.2;
    expect_obs(req, OBS_RD, exp);
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_obs("R1", OBS_OE, 16'h0000);
    expect_obs("R1", OBS_IRQA, 16'h0000);
    expect_obs("R1", OBS_WAKE, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    read_expect("R1", 3'd4, 16'h0000);

    // R2: outputs on the low byte
    reg_write(3'd1, 16'h00FF);
    reg_write(3'd0, 16'hA5A5);
    expect_obs("R2", OBS_OE, 16'h00FF);
    expect_obs("R2", OBS_OUT, 16'hA5A5);

    // R9 readback, R3 level flags, R6 output bit 0 never flags
    set_pins(16'h1201);
    read_expect("R9", 3'd0, 16'h12A5);
    read_expect("R3", 3'd4, 16'h1200);
    read_expect("R6", 3'd4, 16'h1200);

    // R3: clearing a held level flag has no effect
    reg_write(3'd4, 16'hFFFF);
    read_expect("R3", 3'd4, 16'h1200);
    set_pins(16'h0001);
    read_expect("R3", 3'd4, 16'h0000);

    // R4: bit 9 active low
    reg_write(3'd3, 16'h0200);
    repeat (2) @(negedge clk);
    read_expect("R4", 3'd4, 16'h0200);
    set_pins(16'h0201);
    read_expect("R4", 3'd4, 16'h0000);

    // R5: bit 10 rising edge, bit 11 falling edge
    reg_write(3'd3, 16'h0A00);
    reg_write(3'd2, 16'h0C00);
    reg_write(3'd4, 16'h0800);
    read_expect("R5", 3'd4, 16'h0000);
    set_pins(16'h0601);
    read_expect("R5", 3'd4, 16'h0400);
    set_pins(16'h0201);
    read_expect("R5", 3'd4, 16'h0400);
    set_pins(16'h0A01);
    read_expect("R5", 3'd4, 16'h0400);
    set_pins(16'h0201);
    read_expect("R5", 3'd4, 16'h0C00);

    // R7: steering
    reg_write(3'd5, 16'h0400);
    expect_obs("R7", OBS_IRQA, 16'h0001);
    expect_obs("R7", OBS_IRQB, 16'h0000);
    reg_write(3'd6, 16'h0800);
    expect_obs("R7", OBS_IRQB, 16'h0001);
    reg_write(3'd4, 16'h0400);
    expect_obs("R7", OBS_IRQA, 16'h0000);
    expect_obs("R7", OBS_IRQB, 16'h0001);
    read_expect("R5", 3'd4, 16'h0800);

    // R8: wake with no clock edge in between
    reg_write(3'd7, 16'h1000);
    expect_obs("R8", OBS_WAKE, 16'h0000);
    @(posedge clk);
    #1.0;
    pin_in = 16'h1201;
    #0.5;
    expect_obs("R8", OBS_WAKE, 16'h0001);
    reg_write(3'd1, 16'h10FF);
    expect_obs("R8", OBS_WAKE, 16'h0000);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule